// File: doc/BRIEF.md
# SAR Converter Host Controller

This synchronous controller sits between a host and a parallel 16-bit successive-approximation converter. When the host asks for a sample, the controller pulls the conversion-start line low for a fixed number of clocks. It then waits for the converter's active-low busy flag to fall and rise again. Once busy has cleared, it lowers chip select and read together, latches the converter word on the last read cycle and hands it to the host. The word is widened with its sign bit and marked by a one-cycle valid strobe. After each read, an acquisition gap is enforced before the next start is allowed. If busy never completes, a timeout returns the controller to idle and sets a sticky error flag, which a host write clears.

The host can also put the converter into one of two power-down modes. Both hold the shutdown line low. The chip-select level selects which mode: low selects the light mode (nap) and high selects the deep mode (sleep). When the host releases power-down, the controller raises shutdown and waits a wake-up delay before any conversion. The delay depends on the deepest mode used during that power-down: a short one after nap, and a much longer one after sleep, while the reference settles.

Host requests that arrive while the controller is busy, waking or powered down are counted and served in turn from idle, with one result per request. Every delay is given in nanoseconds together with the clock period and turned into a cycle count at elaboration.

Top module: `adc_host_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, the controller rests in idle: `adc_shdn_n_o`, `adc_convst_n_o`, `adc_cs_n_o` and `adc_rd_n_o` are 1, `valid_o` and `err_o` are 0, and `ready_o` is 1.
- R2: A conversion begins with `adc_convst_n_o` low for exactly ceil(T_CONVST_NS/CLK_NS) cycles, which is 2 with the defaults. It is issued only while `adc_shdn_n_o` is 1.
- R3: After `adc_busy_n_i` has been seen low and then returns high, `adc_cs_n_o` and `adc_rd_n_o` go low together for ceil(T_RD_NS/CLK_NS) cycles (3 with the defaults), and never while busy is low. The word on `adc_data_i` in the last read cycle appears on `data_o` with a one-cycle `valid_o`. Bit 15 is copied into bits HOST_W-1 down to 16.
- R4: If busy has not completed within ceil(T_CONV_MAX_NS/CLK_NS)+TMO_MARGIN_CYC cycles of the end of the start pulse (200 with the defaults), no result is strobed, `err_o` rises and the controller is back in idle (`ready_o` = 1) in the same cycle.
- R5: `err_o` stays at 1 until a cycle with `err_clr_i` = 1, after which it reads 0.
- R6: The next fall of `adc_convst_n_o` comes at least ceil(T_ACQ_NS/CLK_NS) cycles (40) after `adc_busy_n_i` rose.
- R7: Requests that arrive during conversion, wake-up or power-down are held. Each produces one result, in order. At most PEND_MAX (4) requests are held, and further ones are dropped.
- R8: With `pd_req_i` = 1 in idle, `adc_shdn_n_o` goes to 0. `adc_cs_n_o` is 0 for nap (`pd_deep_i` = 0) and 1 for sleep (`pd_deep_i` = 1). Raising `pd_deep_i` during nap moves to sleep, and sleep never falls back to nap before wake-up.
- R9: When `pd_req_i` falls, `adc_shdn_n_o` rises. The first start comes exactly ceil(T_NAP_WAKE_NS/CLK_NS)+1 cycles later after nap (21), or ceil(T_SLEEP_WAKE_NS/CLK_NS)+1 cycles later after sleep.
- R10: A request made during power-down issues no start and no result until the wake-up delay has run out.
- R11: `ready_o` is 1 only in idle, and is 0 during conversion, power-down and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle sample request |
| pd_req_i | input | 1 | Level: hold the converter powered down |
| pd_deep_i | input | 1 | Power-down depth: 0 nap, 1 sleep |
| err_clr_i | input | 1 | Host write that clears the timeout flag |
| ready_o | output | 1 | Controller idle and awake |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | HOST_W | Sign-extended result |
| err_o | output | 1 | Sticky conversion-timeout flag |
| adc_convst_n_o | output | 1 | Conversion start, active low |
| adc_cs_n_o | output | 1 | Chip select, active low; sets power-down depth |
| adc_rd_n_o | output | 1 | Read enable, active low |
| adc_shdn_n_o | output | 1 | Shutdown, active low |
| adc_busy_n_i | input | 1 | Converter busy, low while converting |
| adc_data_i | input | ADC_W | Converter output word |

## Verification
Some rules can be checked on every cycle. The assertions do so for the following:
- the minimum distance from wake-up and from busy release to each start;
- no read while busy is low;
- the single-cycle strobe and the sign extension of every result;
- the sticky error and its return to idle;
- no fall back from sleep to nap;
- the pending-count bounds.

Other behaviour needs whole scenarios from the bench's converter model:
- exact widths of the start and read pulses;
- the word order through the scoreboard;
- the exact wake-up latencies after nap and sleep;
- holding requests during power-down;
- dropping requests past the pending limit;
- both timeout paths: busy that never falls, and busy that never rises.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_CONV,
      ST_READ,
      ST_ACQ,
      ST_SD_NAP,
      ST_SD_SLEEP,
      ST_WAKE
   } adcc_state_e;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcc_delay_cnt.sv
module adcc_delay_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/adcc_req_pend.sv
module adcc_req_pend #(
   parameter int PEND_MAX = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic take,
   output logic nz
);

   localparam int PW = $clog2(PEND_MAX + 1);

   logic [PW-1:0] cnt_q;
   logic          inc;

   assign inc = req && (cnt_q != PW'(PEND_MAX));

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else begin
         case ({inc, take})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign nz = (cnt_q != '0);

   AST_PEND_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      take |-> cnt_q != '0);                                              // R7
   AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= PW'(PEND_MAX));                                            // R7

endmodule

// File: rtl/adcc_capture.sv
module adcc_capture #(
   parameter int ADC_W  = 16,
   parameter int HOST_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic [ADC_W-1:0]  din,
   output logic [HOST_W-1:0] dout,
   output logic              valid
);

   logic [HOST_W-1:0] ext;

   generate
      if (HOST_W == ADC_W) begin : g_same
         assign ext = din;
      end else begin : g_wide
         assign ext = {{(HOST_W - ADC_W){din[ADC_W-1]}}, din};
         AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
            valid |-> ((&dout[HOST_W-1:ADC_W-1]) || !(|dout[HOST_W-1:ADC_W-1])));  // R3
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cap;
         if (cap)
            dout <= ext;
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);                                                  // R3

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
   import adcc_pkg::*;
#(
   parameter int ADC_W           = 16,
   parameter int HOST_W          = 32,
   parameter int CLK_NS          = 10,
   parameter int T_CONVST_NS     = 20,
   parameter int T_CONV_MAX_NS   = 1800,
   parameter int TMO_MARGIN_CYC  = 20,
   parameter int T_RD_NS         = 30,
   parameter int T_ACQ_NS        = 400,
   parameter int T_NAP_WAKE_NS   = 200,
   parameter int T_SLEEP_WAKE_NS = 80000000,
   parameter int PEND_MAX        = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic              pd_req_i,
   input  logic              pd_deep_i,
   input  logic              err_clr_i,
   output logic              ready_o,
   output logic              valid_o,
   output logic [HOST_W-1:0] data_o,
   output logic              err_o,
   output logic              adc_convst_n_o,
   output logic              adc_cs_n_o,
   output logic              adc_rd_n_o,
   output logic              adc_shdn_n_o,
   input  logic              adc_busy_n_i,
   input  logic [ADC_W-1:0]  adc_data_i
);

   localparam int START_CYC = cdiv(T_CONVST_NS, CLK_NS);
   localparam int TMO_CYC   = cdiv(T_CONV_MAX_NS, CLK_NS) + TMO_MARGIN_CYC;
   localparam int RD_CYC    = cdiv(T_RD_NS, CLK_NS);
   localparam int ACQ_CYC   = cdiv(T_ACQ_NS, CLK_NS);
   localparam int NAP_CYC   = cdiv(T_NAP_WAKE_NS, CLK_NS);
   localparam int SLEEP_CYC = cdiv(T_SLEEP_WAKE_NS, CLK_NS);
   localparam int MAX_CYC   = imax(imax(imax(START_CYC, TMO_CYC), imax(RD_CYC, ACQ_CYC)),
                                   imax(NAP_CYC, SLEEP_CYC));
   localparam int TW        = $clog2(MAX_CYC + 1);

   generate
      if (HOST_W < ADC_W) begin : g_bad_width
         $error("host bus narrower than converter word");
      end
      if (CLK_NS < 1 || T_CONVST_NS < 1 || T_RD_NS < 1 || T_ACQ_NS < 1 ||
          T_NAP_WAKE_NS < 1 || T_SLEEP_WAKE_NS < 1 || T_CONV_MAX_NS < 1) begin : g_bad_time
         $error("all timing parameters must be positive");
      end
      if (TMO_MARGIN_CYC < 0) begin : g_bad_margin
         $error("timeout margin must not be negative");
      end
      if (PEND_MAX < 1) begin : g_bad_pend
         $error("pending depth must be at least one");
      end
   endgenerate

   adcc_state_e   state_q, state_d;
   logic          t_load, t_done;
   logic [TW-1:0] t_val;
   logic          take, cap, tmo;
   logic          pend_nz;
   logic          seen_busy_q;
   logic          err_q;

   adcc_delay_cnt #(.W(TW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   adcc_req_pend #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk  (clk),
      .rst  (rst),
      .req  (req_i),
      .take (take),
      .nz   (pend_nz)
   );

   adcc_capture #(.ADC_W(ADC_W), .HOST_W(HOST_W)) u_cap (
      .clk   (clk),
      .rst   (rst),
      .cap   (cap),
      .din   (adc_data_i),
      .dout  (data_o),
      .valid (valid_o)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      take    = 1'b0;
      cap     = 1'b0;
      tmo     = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (pd_req_i) begin
               state_d = pd_deep_i ? ST_SD_SLEEP : ST_SD_NAP;
            end else if (pend_nz) begin
               state_d = ST_START;
               t_load  = 1'b1;
               t_val   = TW'(START_CYC - 1);
               take    = 1'b1;
            end
         end
         ST_START: begin
            if (t_done) begin
               state_d = ST_CONV;
               t_load  = 1'b1;
               t_val   = TW'(TMO_CYC - 1);
            end
         end
         ST_CONV: begin
            if (seen_busy_q && adc_busy_n_i) begin
               state_d = ST_READ;
               t_load  = 1'b1;
               t_val   = TW'(RD_CYC - 1);
            end else if (t_done) begin
               state_d = ST_IDLE;
               tmo     = 1'b1;
            end
         end
         ST_READ: begin
            if (t_done) begin
               cap     = 1'b1;
               state_d = ST_ACQ;
               t_load  = 1'b1;
               t_val   = TW'(ACQ_CYC - 1);
            end
         end
         ST_ACQ: begin
            if (t_done)
               state_d = ST_IDLE;
         end
         ST_SD_NAP: begin
            if (!pd_req_i) begin
               state_d = ST_WAKE;
               t_load  = 1'b1;
               t_val   = TW'(NAP_CYC - 1);
            end else if (pd_deep_i) begin
               state_d = ST_SD_SLEEP;
            end
         end
         ST_SD_SLEEP: begin
            if (!pd_req_i) begin
               state_d = ST_WAKE;
               t_load  = 1'b1;
               t_val   = TW'(SLEEP_CYC - 1);
            end
         end
         ST_WAKE: begin
            if (t_done)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         seen_busy_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_START || state_q == ST_CONV)
            seen_busy_q <= seen_busy_q || !adc_busy_n_i;
         else
            seen_busy_q <= 1'b0;
         if (tmo)
            err_q <= 1'b1;
         else if (err_clr_i)
            err_q <= 1'b0;
      end
   end

   assign err_o          = err_q;
   assign ready_o        = (state_q == ST_IDLE);
   assign adc_convst_n_o = (state_q != ST_START);
   assign adc_rd_n_o     = (state_q != ST_READ);
   assign adc_cs_n_o     = !(state_q == ST_READ || state_q == ST_SD_NAP);
   assign adc_shdn_n_o   = !(state_q == ST_SD_NAP || state_q == ST_SD_SLEEP);

   // Checker-only history: cycles since wake, deepest mode used, cycles since busy release.
   logic [TW-1:0] since_wake_q, since_busy_q;
   logic          slept_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_wake_q <= TW'(MAX_CYC);
         since_busy_q <= TW'(MAX_CYC);
         slept_q      <= 1'b0;
      end else begin
         if (!adc_shdn_n_o)
            since_wake_q <= '0;
         else if (since_wake_q < TW'(MAX_CYC))
            since_wake_q <= since_wake_q + 1'b1;
         if (!adc_busy_n_i)
            since_busy_q <= '0;
         else if (since_busy_q < TW'(MAX_CYC))
            since_busy_q <= since_busy_q + 1'b1;
         if (!adc_shdn_n_o)
            slept_q <= adc_cs_n_o;
      end
   end

   AST_WAKE_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(adc_convst_n_o) |-> since_wake_q >= (slept_q ? TW'(SLEEP_CYC) : TW'(NAP_CYC)));  // R9
   AST_ACQ_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(adc_convst_n_o) |-> since_busy_q >= TW'(ACQ_CYC));                                // R6
   AST_READ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      !adc_rd_n_o |-> adc_busy_n_i && !adc_cs_n_o);                                           // R3
   AST_START_AWAKE: assert property (@(posedge clk) disable iff (rst)
      $fell(adc_convst_n_o) |-> $past(adc_shdn_n_o));                                         // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_o && !err_clr_i |=> err_o);                                                         // R5
   AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      $rose(err_o) |-> ready_o && !valid_o);                                                  // R4
   AST_NO_SLEEP_TO_NAP: assert property (@(posedge clk) disable iff (rst)
      !adc_shdn_n_o && $past(!adc_shdn_n_o) && $past(adc_cs_n_o) |-> adc_cs_n_o);             // R8

endmodule

// File: tb/adc_host_ctrl_test.sv
module adc_host_ctrl_test;

   localparam int CLK_P     = 10;
   localparam int START_CYC = 2;
   localparam int RD_CYC    = 3;
   localparam int ACQ_CYC   = 40;
   localparam int NAP_CYC   = 20;
   localparam int SLEEP_CYC = 500;
   localparam int CONV_LEN  = 145;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_i = 1'b0, pd_req_i = 1'b0, pd_deep_i = 1'b0, err_clr_i = 1'b0;
   logic        ready_o, valid_o, err_o;
   logic [31:0] data_o;
   logic        adc_convst_n_o, adc_cs_n_o, adc_rd_n_o, adc_shdn_n_o;
   logic        adc_busy_n_i = 1'b1;
   logic [15:0] adc_data_i;
   logic [15:0] cur_word = 16'h0;

   always #(CLK_P/2) clk = ~clk;

   adc_host_ctrl #(.T_SLEEP_WAKE_NS(SLEEP_CYC * CLK_P)) uut (
      .clk(clk), .rst(rst), .req_i(req_i), .pd_req_i(pd_req_i), .pd_deep_i(pd_deep_i),
      .err_clr_i(err_clr_i), .ready_o(ready_o), .valid_o(valid_o), .data_o(data_o),
      .err_o(err_o), .adc_convst_n_o(adc_convst_n_o), .adc_cs_n_o(adc_cs_n_o),
      .adc_rd_n_o(adc_rd_n_o), .adc_shdn_n_o(adc_shdn_n_o), .adc_busy_n_i(adc_busy_n_i),
      .adc_data_i(adc_data_i)
   );

   int n_chk = 0, n_bad = 0;
   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // converter model: 0 normal, 1 busy never falls, 2 busy never rises
   int          mode = 0;
   logic [15:0] mdl_q[$];
   logic [31:0] exp_q[$];

   assign adc_data_i = (!adc_cs_n_o && !adc_rd_n_o) ? cur_word : 16'h0;

   initial begin
      forever begin
         @(negedge adc_convst_n_o);
         if (mode == 1) continue;
         @(negedge clk);
         adc_busy_n_i = 1'b0;
         if (mode == 2) continue;
         repeat (CONV_LEN) @(negedge clk);
         if (mdl_q.size() == 0) check(0, "R7 model word missing", 0, 1);
         else cur_word = mdl_q.pop_front();
         adc_busy_n_i = 1'b1;
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && valid_o) begin
            if (exp_q.size() == 0) check(0, "R7 unexpected result", data_o, 0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               check(data_o === e, "R3 result word", data_o, e);
            end
         end
      end
   end

   // pulse-width and gap monitors
   time t_cs_fall, t_rd_fall, t_wake, t_busy_rise;
   bit  wake_armed = 0, busy_armed = 0;
   longint wake_gap = -1;

   initial forever begin
      @(negedge adc_convst_n_o);
      t_cs_fall = $time;
      if (wake_armed) begin wake_gap = ($time - t_wake) / CLK_P; wake_armed = 0; end
      if (busy_armed) begin
         check(($time - t_busy_rise) >= ACQ_CYC * CLK_P, "R6 acquisition gap",
               ($time - t_busy_rise) / CLK_P, ACQ_CYC);
         busy_armed = 0;
      end
      @(posedge adc_convst_n_o);
      check(($time - t_cs_fall) == START_CYC * CLK_P, "R2 start pulse width",
            ($time - t_cs_fall) / CLK_P, START_CYC);
   end

   initial forever begin
      @(negedge adc_rd_n_o);
      t_rd_fall = $time;
      check(adc_cs_n_o === 1'b0 && adc_busy_n_i === 1'b1, "R3 read with select, not busy",
            {adc_cs_n_o, adc_busy_n_i}, 2'b01);
      @(posedge adc_rd_n_o);
      check(($time - t_rd_fall) == RD_CYC * CLK_P, "R3 read pulse width",
            ($time - t_rd_fall) / CLK_P, RD_CYC);
   end

   initial forever begin @(posedge adc_shdn_n_o); t_wake = $time; wake_armed = 1; end
   initial forever begin @(posedge adc_busy_n_i); t_busy_rise = $time; busy_armed = 1; end

   task automatic do_req(input logic [15:0] w, input bit push);
      if (push) begin
         mdl_q.push_back(w);
         exp_q.push_back({{16{w[15]}}, w});
      end
      @(negedge clk) req_i = 1'b1;
      @(negedge clk) req_i = 1'b0;
   endtask

   task automatic wait_drain();
      int t = 0;
      @(negedge clk);
      while ((exp_q.size() != 0 || !ready_o) && t < 20000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      check({adc_shdn_n_o, adc_convst_n_o, adc_cs_n_o, adc_rd_n_o} === 4'hF, "R1 pins in reset",
            {adc_shdn_n_o, adc_convst_n_o, adc_cs_n_o, adc_rd_n_o}, 4'hF);
      check({valid_o, err_o, ready_o} === 3'b001, "R1 flags in reset",
            {valid_o, err_o, ready_o}, 3'b001);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(ready_o === 1'b1 && adc_shdn_n_o === 1'b1, "R1 idle after reset",
            {ready_o, adc_shdn_n_o}, 2'b11);

      // single conversion, ready low while working (R11)
      do_req(16'h1234, 1);
      repeat (20) @(negedge clk);
      check(ready_o === 1'b0, "R11 ready low in conversion", ready_o, 0);
      wait_drain();

      // back-to-back requests, sign extension and order (R3, R6, R7)
      do_req(16'h8001, 1);
      do_req(16'hFFFF, 1);
      do_req(16'h7FFF, 1);
      wait_drain();
      check(exp_q.size() == 0, "R7 queued requests all served", exp_q.size(), 0);

      // timeout: busy never falls (R4)
      mode = 1;
      do_req(16'h0, 0);
      repeat (260) @(negedge clk);
      check(err_o === 1'b1, "R4 timeout flag, busy never fell", err_o, 1);
      check(ready_o === 1'b1, "R4 back in idle after timeout", ready_o, 1);
      repeat (10) @(negedge clk);
      check(err_o === 1'b1, "R5 error held", err_o, 1);
      err_clr_i = 1'b1;
      @(negedge clk) err_clr_i = 1'b0;
      check(err_o === 1'b0, "R5 error cleared", err_o, 0);

      // timeout: busy never rises (R4)
      mode = 2;
      do_req(16'h0, 0);
      repeat (260) @(negedge clk);
      check(err_o === 1'b1, "R4 timeout flag, busy stuck", err_o, 1);
      mode = 0;
      adc_busy_n_i = 1'b1;
      busy_armed = 0;
      err_clr_i = 1'b1;
      @(negedge clk) err_clr_i = 1'b0;
      repeat (60) @(negedge clk);
      check(err_o === 1'b0, "R5 error cleared again", err_o, 0);

      // nap with a held request (R8, R9, R10, R11)
      pd_deep_i = 1'b0;
      pd_req_i = 1'b1;
      repeat (3) @(negedge clk);
      check({adc_shdn_n_o, adc_cs_n_o} === 2'b00, "R8 nap pins", {adc_shdn_n_o, adc_cs_n_o}, 2'b00);
      check(ready_o === 1'b0, "R11 ready low in power-down", ready_o, 0);
      do_req(16'hABCD, 1);
      repeat (10) @(negedge clk);
      check(adc_convst_n_o === 1'b1 && exp_q.size() == 1, "R10 no start while napping",
            {adc_convst_n_o, 8'(exp_q.size())}, 9'h101);
      pd_req_i = 1'b0;
      wait_drain();
      check(wake_gap == NAP_CYC + 1, "R9 nap wake latency", wake_gap, NAP_CYC + 1);

      // nap promoted to sleep, sleep held (R8, R9)
      pd_req_i = 1'b1;
      repeat (5) @(negedge clk);
      pd_deep_i = 1'b1;
      repeat (3) @(negedge clk);
      check({adc_shdn_n_o, adc_cs_n_o} === 2'b01, "R8 nap to sleep", {adc_shdn_n_o, adc_cs_n_o}, 2'b01);
      pd_deep_i = 1'b0;
      repeat (3) @(negedge clk);
      check({adc_shdn_n_o, adc_cs_n_o} === 2'b01, "R8 sleep held", {adc_shdn_n_o, adc_cs_n_o}, 2'b01);
      do_req(16'h0F0F, 1);
      pd_req_i = 1'b0;
      repeat (SLEEP_CYC - 10) @(negedge clk);
      check(adc_convst_n_o === 1'b1 && ready_o === 1'b0, "R10 no start during sleep wake",
            {adc_convst_n_o, ready_o}, 2'b10);
      wait_drain();
      check(wake_gap == SLEEP_CYC + 1, "R9 sleep wake latency", wake_gap, SLEEP_CYC + 1);

      // direct sleep, pending saturation (R7, R8)
      pd_deep_i = 1'b1;
      pd_req_i = 1'b1;
      repeat (3) @(negedge clk);
      check({adc_shdn_n_o, adc_cs_n_o} === 2'b01, "R8 sleep pins", {adc_shdn_n_o, adc_cs_n_o}, 2'b01);
      do_req(16'h0001, 1);
      do_req(16'h8000, 1);
      do_req(16'h4321, 1);
      do_req(16'hC000, 1);
      do_req(16'h5555, 0);
      do_req(16'h6666, 0);
      pd_req_i = 1'b0;
      pd_deep_i = 1'b0;
      wait_drain();
      repeat (600) @(negedge clk);
      check(exp_q.size() == 0 && mdl_q.size() == 0, "R7 four held, extras dropped",
            exp_q.size() + mdl_q.size(), 0);
      check(ready_o === 1'b1 && adc_convst_n_o === 1'b1, "R7 idle after saturated drain",
            {ready_o, adc_convst_n_o}, 2'b11);
      summary();
   end

endmodule